// File: doc/BRIEF.md
# Phase-Continuous FSK Sine Modulator

This block turns a serial bit level into a stream of unsigned sine samples for an external DAC. While the level is high it produces a 1200 Hz tone; while low, a 2200 Hz tone. A phase accumulator, clocked from a 3.6864 MHz reference, advances by one of two tuning words each cycle. Its top bits address a sine table that is computed when the design is elaborated. A change of tone only changes the step size. The accumulated phase is never cleared, so the waveform has no jump at a bit boundary.

The host drives characters at about 1200 bit/s, each character 11 bits (start, eight data bits, parity, stop). The modulator does not decode any framing. It follows the bit input level as it arrives. An active-low request-to-send input enables transmit. While that input is high, the modulator rests: the phase is frozen and the output sits at mid-scale, leaving the line to a receive path outside this block.

Top module: `fsk_sine_mod`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dac_code` becomes 512 and the phase is cleared to zero. The first enabled sample after reset is therefore 512.
- R2: After any edge at which `tx_req_n` is high, `dac_code` is exactly 512, whatever `tx_bit` does.
- R3: While `tx_req_n` is high, the phase does not move. When transmit resumes, the waveform continues from the held phase.
- R4: At each enabled edge with `tx_bit` = 1, the 24-bit phase advances by 5461 modulo 2^24. The resulting tone period is 3072 clock cycles within ±1% (1200 Hz).
- R5: At each enabled edge with `tx_bit` = 0, the phase advances by 10012 modulo 2^24. The resulting tone period is 1676 clock cycles within ±1% (2200 Hz).
- R6: After an enabled edge, `dac_code` equals 512 + round(511·sin(2π·k/256)) within ±1 code. Here k is phase bits [23:16] as they were before that edge, so the output lags the phase by one register.
- R7: Two consecutive enabled samples never differ by more than 13 codes, including across every change of `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.6864 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req_n | input | 1 | Low selects transmit; high rests the modulator |
| tx_bit | input | 1 | Serial data level: 1 selects the low tone, 0 the high tone |
| dac_code | output | 10 | Unsigned sine sample, mid-scale 512 |

## Verification
The bench builds the block with its default parameters: a 3.6864 MHz clock, a 24-bit phase and a 10-bit sample from a 256-entry table. With these values the two real tones can be timed by counting rising mid-scale crossings, which takes a few thousand cycles per period. A behavioural reference, built from integers and real-valued sine, tracks the phase and the expected sample on every clock. The bench also drives a full 11-bit character at the true bit period. This puts every mark/space switch, a pause of the request input partway through a tone, and a reset partway through a run within reach of exact comparison.

// File: rtl/fsk_mod_pkg.sv
// Package: shared types and elaboration-time helpers for the FSK modulator.
// Assumes: parameters are small enough that a 64-bit intermediate never
// overflows (accumulator width up to 32, sample width up to 16).
package fsk_mod_pkg;

    // Tone selected by the serial data level.
    typedef enum logic {
        TONE_SPACE = 1'b0,
        TONE_MARK  = 1'b1
    } tone_e;

    // Fixed-point fraction width used while building the sine table.
    localparam int  FRAC_W = 28;
    // pi scaled by 2^FRAC_W, rounded.
    localparam longint PI_FX = 64'sd843314857;

    // Phase step per clock: round(tone * 2^acc_w / clk).
    function automatic int unsigned tuning_word(input longint unsigned clk_hz,
                                                input longint unsigned tone_hz,
                                                input int acc_w);
        longint unsigned num;
        num = tone_hz << acc_w;
        return int'((num + clk_hz / 2) / clk_hz);
    endfunction

    // Unsigned sample for table entry idx of a 2^idx_w table:
    // mid + round(amp * sin(2*pi*idx / 2^idx_w)), built from a quarter wave
    // and a Taylor series so no real arithmetic reaches the hardware.
    function automatic int sine_code(input int idx, input int idx_w, input int smp_w);
        int     quarter;
        int     quad;
        int     r;
        int     amp;
        int     mag;
        longint x;
        longint x2;
        longint term;
        longint sum;
        quarter = 1 << (idx_w - 2);
        quad    = idx / quarter;
        r       = idx % quarter;
        amp     = (1 << (smp_w - 1)) - 1;
        if (quad == 1 || quad == 3) begin
            r = quarter - r;
        end
        x    = (longint'(r) * 2 * PI_FX) / (longint'(1) << idx_w);
        x2   = (x * x) >>> FRAC_W;
        term = x;
        sum  = x;
        for (int k = 1; k <= 5; k++) begin
            term = -((term * x2) >>> FRAC_W) / longint'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        mag = int'((sum * amp + (longint'(1) <<< (FRAC_W - 1))) >>> FRAC_W);
        if (quad >= 2) begin
            mag = -mag;
        end
        return (1 << (smp_w - 1)) + mag;
    endfunction

endpackage

// File: rtl/fsk_tone_sel.sv
// Module: fsk_tone_sel
// Maps the serial data level to a phase step. A high level picks the mark
// step, a low level the space step.
// Assumes: the data input is already synchronous to the modulator clock.
module fsk_tone_sel
    import fsk_mod_pkg::*;
#(
    parameter int          ACC_W    = 24,
    parameter int unsigned MARK_TW  = 5461,
    parameter int unsigned SPACE_TW = 10012
) (
    input  logic             bit_i,
    output logic [ACC_W-1:0] step_o
);

    localparam logic [ACC_W-1:0] MARK_STEP  = ACC_W'(MARK_TW);
    localparam logic [ACC_W-1:0] SPACE_STEP = ACC_W'(SPACE_TW);

    tone_e tone;

    // Interpret the data level as a tone.
    always_comb begin
        tone = tone_e'(bit_i);
    end

    // Choose the step for the selected tone.
    always_comb begin
        unique case (tone)
            TONE_MARK:  step_o = MARK_STEP;
            TONE_SPACE: step_o = SPACE_STEP;
            default:    step_o = SPACE_STEP;
        endcase
    end

endmodule

// File: rtl/fsk_phase_acc.sv
// Module: fsk_phase_acc
// Wrapping phase accumulator. It adds the step on each enabled clock and
// holds otherwise. It is never cleared on a tone change, which is what keeps
// the waveform continuous. Exposes only the table index (top IDX_W bits).
// Assumes: step < 2^(ACC_W-IDX_W), so the index moves at most one per clock.
module fsk_phase_acc #(
    parameter int ACC_W = 24,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] step,
    output logic [IDX_W-1:0] idx_o
);

    logic [ACC_W-1:0] phase_q;

    // Advance the phase while enabled, freeze it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= phase_q + step;
        end
    end

    // Coarse phase used to address the sine table.
    assign idx_o = phase_q[ACC_W-1 -: IDX_W];

endmodule

// File: rtl/fsk_sine_rom.sv
// Module: fsk_sine_rom
// Full-wave sine table, computed at elaboration, with a registered read.
// While disabled or in reset the registered output is forced to mid-scale.
// Assumes: IDX_W >= 2 so that a quarter wave exists.
module fsk_sine_rom
    import fsk_mod_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int SMP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [SMP_W-1:0] code_q
);

    localparam int               DEPTH = 1 << IDX_W;
    localparam logic [SMP_W-1:0] MID   = {1'b1, {(SMP_W-1){1'b0}}};

    logic [SMP_W-1:0] table_w [DEPTH];

    // One constant entry per table position.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_w[i] = SMP_W'(sine_code(i, IDX_W, SMP_W));
    end

    // Register the looked-up sample, or mid-scale when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= MID;
        end else if (en) begin
            code_q <= table_w[idx];
        end else begin
            code_q <= MID;
        end
    end

endmodule

// File: rtl/fsk_sine_mod.sv
// Module: fsk_sine_mod (top)
// Phase-continuous two-tone sine generator for a half-duplex modem line.
// An active-low request input enables transmit. The data level picks the
// tone, and the samples leave one register after the phase they represent.
// Assumes: all inputs are synchronous to clk; framing is handled by the host.
module fsk_sine_mod
    import fsk_mod_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 3686400,
    parameter int unsigned MARK_HZ  = 1200,
    parameter int unsigned SPACE_HZ = 2200,
    parameter int          ACC_W    = 24,
    parameter int          IDX_W    = 8,
    parameter int          SMP_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_req_n,
    input  logic             tx_bit,
    output logic [SMP_W-1:0] dac_code
);

    localparam int unsigned MARK_TW  = tuning_word(CLK_HZ, MARK_HZ, ACC_W);
    localparam int unsigned SPACE_TW = tuning_word(CLK_HZ, SPACE_HZ, ACC_W);

    logic             tx_en;
    logic [ACC_W-1:0] step;
    logic [IDX_W-1:0] idx;

    // Transmit is active while the request input is low.
    assign tx_en = ~tx_req_n;

    fsk_tone_sel #(
        .ACC_W    (ACC_W),
        .MARK_TW  (MARK_TW),
        .SPACE_TW (SPACE_TW)
    ) u_sel (
        .bit_i  (tx_bit),
        .step_o (step)
    );

    fsk_phase_acc #(
        .ACC_W (ACC_W),
        .IDX_W (IDX_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tx_en),
        .step  (step),
        .idx_o (idx)
    );

    fsk_sine_rom #(
        .IDX_W (IDX_W),
        .SMP_W (SMP_W)
    ) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tx_en),
        .idx    (idx),
        .code_q (dac_code)
    );

endmodule

// File: rtl/fsk_sine_mod_chk.sv
// Module: fsk_sine_mod_chk
// Temporal checks on the modulator: idle level, phase freeze, step sizes
// and bounded sample-to-sample change. Bound into every fsk_sine_mod.
module fsk_sine_mod_chk #(
    parameter int          ACC_W    = 24,
    parameter int          IDX_W    = 8,
    parameter int          SMP_W    = 10,
    parameter int unsigned MARK_TW  = 5461,
    parameter int unsigned SPACE_TW = 10012
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_req_n,
    input logic             tx_bit,
    input logic [ACC_W-1:0] phase,
    input logic [SMP_W-1:0] dac_code
);

    localparam logic [SMP_W-1:0] MID      = {1'b1, {(SMP_W-1){1'b0}}};
    localparam int               AMP      = (1 << (SMP_W - 1)) - 1;
    localparam int               SCALE    = 10000 * (1 << IDX_W);
    localparam int               MAX_STEP = (AMP * 62832 + SCALE - 1) / SCALE;

    // R1
    reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dac_code == MID);

    // R2
    idle_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_req_n)) |-> dac_code == MID);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_req_n)) |-> phase == $past(phase));

    // R4
    mark_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tx_req_n) && $past(tx_bit))
        |-> phase == ACC_W'($past(phase) + ACC_W'(MARK_TW)));

    // R5
    space_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tx_req_n) && !$past(tx_bit))
        |-> phase == ACC_W'($past(phase) + ACC_W'(SPACE_TW)));

    // R7
    smooth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tx_req_n) && $past(rst_n, 2) && !$past(tx_req_n, 2))
        |-> ((dac_code >= $past(dac_code)) ? (int'(dac_code) - int'($past(dac_code)))
                                           : (int'($past(dac_code)) - int'(dac_code)))
            <= MAX_STEP);

endmodule

bind fsk_sine_mod fsk_sine_mod_chk #(
    .ACC_W    (ACC_W),
    .IDX_W    (IDX_W),
    .SMP_W    (SMP_W),
    .MARK_TW  (MARK_TW),
    .SPACE_TW (SPACE_TW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_req_n (tx_req_n),
    .tx_bit   (tx_bit),
    .phase    (u_acc.phase_q),
    .dac_code (dac_code)
);

// File: tb/tb_fsk_sine_mod.sv
`timescale 1ns/1ps
// Bench: behavioural reference compared on every clock, plus tone-period
// and switch-point measurements at the ports.
module tb_fsk_sine_mod;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_req_n = 1'b1;
    logic       tx_bit = 1'b1;
    logic [9:0] dac_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fsk_sine_mod dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_req_n (tx_req_n),
        .tx_bit   (tx_bit),
        .dac_code (dac_code)
    );

    // Reference sample: 512 + round(511*sin(2*pi*k/256)).
    function automatic int sine_ref(input int k);
        real v;
        v = 511.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 256.0);
        return 512 + $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    // Reference state, updated at each rising edge.
    int    m_acc = 0;
    int    m_exp = 512;
    bit    m_exact = 1'b1;
    bit    m_valid = 1'b0;
    string m_tag = "R1";
    bit    m_held = 1'b0;
    bit    m_fresh = 1'b0;
    bit    m_en_now = 1'b0;
    bit    m_en_prev = 1'b0;
    logic  m_last_bit = 1'b1;
    int    sw_cnt = 0;
    int    cyc = 0;
    int    prev_d = 512;
    int    cross_q[$];

    always @(posedge clk) begin
        cyc++;
        m_valid   = 1'b1;
        m_en_prev = m_en_now;
        m_en_now  = rst_n && !tx_req_n;
        if (!rst_n) begin
            m_acc = 0; m_exp = 512; m_exact = 1'b1; m_tag = "R1";
            m_held = 1'b0; m_fresh = 1'b1;
        end else if (tx_req_n) begin
            m_exp = 512; m_exact = 1'b1; m_tag = "R2";
            m_held = 1'b1;
        end else begin
            m_exp   = sine_ref(m_acc >> 16);
            m_exact = 1'b0;
            m_tag   = m_fresh ? "R1" : (m_held ? "R3" : "R6");
            m_fresh = 1'b0;
            m_held  = 1'b0;
            m_acc   = (m_acc + (tx_bit ? 5461 : 10012)) % 16777216;
        end
        if (m_en_now && tx_bit !== m_last_bit) sw_cnt = 3;
        else if (sw_cnt > 0) sw_cnt--;
        m_last_bit = tx_bit;
    end

    // Compare outputs away from the active edge.
    always @(negedge clk) begin
        if (m_valid) begin
            int d;
            int st;
            bit ok;
            d = int'(dac_code);
            n_tests++;
            ok = m_exact ? (d == m_exp) : (d >= m_exp - 1 && d <= m_exp + 1);
            if (!ok) begin
                n_fail++;
                $display("FAIL %s: dac_code=%0d expected=%0d (cycle %0d)", m_tag, d, m_exp, cyc);
            end
            if (prev_d < 512 && d >= 512) cross_q.push_back(cyc);
            if (m_en_now && m_en_prev && sw_cnt > 0) begin
                st = (d >= prev_d) ? d - prev_d : prev_d - d;
                n_tests++;
                if (st > 13) begin
                    n_fail++;
                    $display("FAIL R7: step at switch=%0d expected<=13", st);
                end
            end
            prev_d = d;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Check every period between consecutive rising crossings.
    task automatic check_periods(input string tag, input int lo, input int hi);
        n_tests++;
        if (cross_q.size() < 3) begin
            n_fail++;
            $display("FAIL %s: crossings=%0d expected>=3", tag, cross_q.size());
        end
        for (int i = 1; i < cross_q.size(); i++) begin
            int p;
            p = cross_q[i] - cross_q[i-1];
            n_tests++;
            if (p < lo || p > hi) begin
                n_fail++;
                $display("FAIL %s: period=%0d expected %0d..%0d", tag, p, lo, hi);
            end
        end
    endtask

    initial begin
        logic [10:0] frame;
        wait_cycles(5);
        rst_n = 1'b1;
        // R2: idle with toggling data must stay at mid-scale.
        for (int i = 0; i < 20; i++) begin
            tx_bit = ~tx_bit;
            wait_cycles(1);
        end
        // R4: steady mark tone period.
        tx_bit = 1'b1;
        tx_req_n = 1'b0;
        cross_q.delete();
        wait_cycles(4 * 3072 + 100);
        check_periods("R4", 3041, 3103);
        // R5: steady space tone period.
        tx_bit = 1'b0;
        wait_cycles(3);
        cross_q.delete();
        wait_cycles(5 * 1676 + 100);
        check_periods("R5", 1659, 1693);
        // R7: one character at the true bit period: start, 0xA5 LSB first,
        // even parity, stop.
        frame = {1'b1, ^8'hA5, 8'hA5, 1'b0};
        for (int b = 0; b < 11; b++) begin
            tx_bit = frame[b];
            wait_cycles(3072);
        end
        // R3: pause mid-tone, toggle data, then resume from the held phase.
        tx_bit = 1'b0;
        wait_cycles(700);
        tx_req_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            tx_bit = ~tx_bit;
            wait_cycles(1);
        end
        tx_bit = 1'b1;
        tx_req_n = 1'b0;
        wait_cycles(400);
        // R1: reset while transmitting; first sample must restart at zero phase.
        rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        wait_cycles(300);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1900000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule